// File: doc/BRIEF.md
# VLAN Tag Inserter with Minimum-Size Padding

This block sits on the transmit path. It takes an untagged Ethernet frame, which already holds the destination MAC, the source MAC and the EtherType, and puts a four-byte 802.1Q tag directly after the source MAC. Frames enter and leave on a 64-bit valid/ready stream. Byte lane 0 carries the earliest byte on the wire, and the final beat is marked by `last` together with a one-hot byte-enable. The tag is half a data word wide, so every input byte from the EtherType onward moves up by four lanes. When the input's final beat holds more than four bytes, the block emits one extra output beat to flush the remainder.

A 12-bit VLAN ID comes in on a side input and is expected to stay steady for the whole frame. The priority and drop-eligible bits in the tag are always zero. Short frames are padded with zeros, so that the tagged frame, without its FCS, is never smaller than the minimum frame length minus the FCS. Preamble, FCS and line coding are handled further downstream.

Top module: `vlan_tag_inserter`

## Requirements
- R1: Output bytes 0 to 11 equal input bytes 0 to 11. The byte at stream offset n sits in beat n/8, lane n%8.
- R2: Output bytes 12 to 15 are 0x81, 0x00, {4'b0000, vid_i[11:8]}, vid_i[7:0]. The priority and drop-eligible bits are zero.
- R3: Each input byte at offset k, for k of 12 or more and k below the input length L, appears at output offset k+4.
- R4: With the default minimum frame of 64 bytes and an FCS of 4 bytes, the output length is max(L, 56)+4 bytes. The input length L must be at least 14.
- R5: Bytes added by padding are zero. Input bytes above the one marked by the final beat's byte-enable are discarded.
- R6: The byte-enable is one-hot on the final beat: bit k set means lanes 0 to k are valid. This holds for `s_be_i` on input and for `m_be_o` on output. On every other input beat, all eight lanes are valid.
- R7: After the input's final beat is accepted, `s_ready_o` stays low until the output's final beat is accepted. A frame produces ceil(output length/8) output beats.
- R8: While `m_valid_o` is high and `m_ready_i` is low, the output beat holds steady. No byte is lost or duplicated under any backpressure, and `s_ready_o` is never high while `m_ready_i` is low.
- R9: During reset, and afterwards with no input offered, `m_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_i | input | 12 | VLAN ID placed in the tag |
| s_valid_i | input | 1 | Input beat valid |
| s_ready_o | output | 1 | Input beat accepted |
| s_data_i | input | 64 | Input bytes, lane 0 first on the wire |
| s_last_i | input | 1 | Final input beat of a frame |
| s_be_i | input | 8 | One-hot last-byte marker on the final input beat |
| m_valid_o | output | 1 | Output beat valid |
| m_ready_i | input | 1 | Downstream accepts the output beat |
| m_data_o | output | 64 | Output bytes, lane 0 first on the wire |
| m_last_o | output | 1 | Final output beat of a frame |
| m_be_o | output | 8 | One-hot last-byte marker on the final output beat |

## Verification
The checks assume that the upstream source obeys the stream protocol. It holds a beat steady until accepted, sends frames of at least 14 bytes, sets a single byte-enable bit on the final beat, and keeps `vid_i` fixed during a frame. The stimulus follows these rules. Each beat is presented with random idle gaps and held until its handshake completes, and `vid_i` changes only between frames. On the final beat, the bench fills the lanes above the byte-enable with nonzero junk so that the discard rule is exercised. Frame lengths cover every residue around the 56-byte padding threshold, under random downstream stalls.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int unsigned LANES     = 8;
  localparam int unsigned DW        = LANES * 8;
  localparam int unsigned HALF_W    = DW / 2;
  localparam int unsigned TAG_BYTES = 4;
  localparam logic [15:0] TPID      = 16'h8100;

  // one-hot last-byte marker -> valid byte count (1..LANES)
  function automatic logic [3:0] be_to_cnt(input logic [LANES-1:0] be);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < LANES; i++) if (be[i]) n = 4'(i + 1);
    return n;
  endfunction

  function automatic logic [LANES-1:0] cnt_to_be(input logic [3:0] n);
    logic [LANES-1:0] be;
    be = '0;
    for (int i = 0; i < LANES; i++) if (n == 4'(i + 1)) be[i] = 1'b1;
    return be;
  endfunction
endpackage

// File: rtl/vtag_pad_src.sv
// Turns the input stream into a padded virtual stream with a beat index.
module vtag_pad_src
  import vtag_pkg::*;
#(
  parameter int unsigned MIN_BEATS  = 7,
  parameter int unsigned MIN_LAST_N = 8,
  parameter int unsigned IW         = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [DW-1:0]    s_data_i,
  input  logic             s_last_i,
  input  logic [LANES-1:0] s_be_i,
  output logic             v_valid_o,
  input  logic             v_ready_i,
  output logic [DW-1:0]    v_data_o,
  output logic             v_last_o,
  output logic [3:0]       v_n_o,
  output logic [IW-1:0]    v_idx_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(MIN_BEATS - 1);
  localparam logic [IW-1:0] SAT_IDX  = IW'(MIN_BEATS);

  logic          pad_q;
  logic [IW-1:0] idx_q;
  logic [3:0]    real_n;
  logic [DW-1:0] masked;
  logic          at_min, below_min, take;

  always_comb begin
    real_n = s_last_i ? be_to_cnt(s_be_i) : 4'(LANES);
    for (int i = 0; i < LANES; i++)
      masked[i*8 +: 8] = (4'(i) < real_n) ? s_data_i[i*8 +: 8] : 8'h00;
    at_min    = (idx_q == LAST_IDX);
    below_min = (idx_q < LAST_IDX);
    if (pad_q) begin
      v_valid_o = 1'b1;
      v_data_o  = '0;
      v_last_o  = at_min;
      v_n_o     = 4'(MIN_LAST_N);
      s_ready_o = 1'b0;
    end else begin
      v_valid_o = s_valid_i;
      v_data_o  = masked;
      v_last_o  = s_last_i && !below_min;
      v_n_o     = (at_min && real_n < 4'(MIN_LAST_N)) ? 4'(MIN_LAST_N) : real_n;
      s_ready_o = v_ready_i;
    end
  end

  assign take    = v_valid_o && v_ready_i;
  assign v_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pad_q <= 1'b0;
    end else if (take) begin
      if (v_last_o) idx_q <= '0;
      else if (idx_q != SAT_IDX) idx_q <= idx_q + 1'b1;
      if (!pad_q && s_last_i && below_min) pad_q <= 1'b1;
      else if (pad_q && v_last_o) pad_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vtag_align.sv
// Inserts the tag on beat 1 and realigns later beats by half a word.
module vtag_align
  import vtag_pkg::*;
#(
  parameter int unsigned IW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      vid_i,
  input  logic             v_valid_i,
  output logic             v_ready_o,
  input  logic [DW-1:0]    v_data_i,
  input  logic             v_last_i,
  input  logic [3:0]       v_n_i,
  input  logic [IW-1:0]    v_idx_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [DW-1:0]    m_data_o,
  output logic             m_last_o,
  output logic [LANES-1:0] m_be_o
);
  localparam logic [3:0] HALF_N = 4'(LANES / 2);

  logic              tail_q;
  logic [3:0]        tail_n_q;
  logic [HALF_W-1:0] hold_q;
  logic [HALF_W-1:0] tag_w;
  logic              spill;

  assign tag_w = {vid_i[7:0], 4'h0, vid_i[11:8], TPID[7:0], TPID[15:8]};

  always_comb begin
    spill = 1'b0;
    if (tail_q) begin
      m_valid_o = 1'b1;
      m_data_o  = {{HALF_W{1'b0}}, hold_q};
      m_last_o  = 1'b1;
      m_be_o    = cnt_to_be(tail_n_q);
      v_ready_o = 1'b0;
    end else begin
      m_valid_o = v_valid_i;
      v_ready_o = m_ready_i;
      m_last_o  = 1'b0;
      m_be_o    = '0;
      if (v_idx_i == IW'(0)) begin
        m_data_o = v_data_i;
      end else if (v_idx_i == IW'(1)) begin
        m_data_o = {tag_w, v_data_i[HALF_W-1:0]};
      end else begin
        m_data_o = {v_data_i[HALF_W-1:0], hold_q};
        if (v_last_i) begin
          if (v_n_i <= HALF_N) begin
            m_last_o = 1'b1;
            m_be_o   = cnt_to_be(v_n_i + HALF_N);
          end else begin
            spill = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q   <= 1'b0;
      tail_n_q <= '0;
      hold_q   <= '0;
    end else begin
      if (v_valid_i && v_ready_o) hold_q <= v_data_i[DW-1:HALF_W];
      if (v_valid_i && v_ready_o && spill) begin
        tail_q   <= 1'b1;
        tail_n_q <= v_n_i - HALF_N;
      end else if (tail_q && m_ready_i) begin
        tail_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vlan_tag_inserter.sv
module vlan_tag_inserter
  import vtag_pkg::*;
#(
  parameter int unsigned MIN_FRAME_BYTES = 64,
  parameter int unsigned FCS_BYTES       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [11:0]      vid_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [DW-1:0]    s_data_i,
  input  logic             s_last_i,
  input  logic [LANES-1:0] s_be_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [DW-1:0]    m_data_o,
  output logic             m_last_o,
  output logic [LANES-1:0] m_be_o
);
  // smallest untagged input (no FCS) whose tagged form meets the minimum
  localparam int unsigned MIN_IN     = MIN_FRAME_BYTES - FCS_BYTES - TAG_BYTES;
  localparam int unsigned MIN_BEATS  = (MIN_IN + LANES - 1) / LANES;
  localparam int unsigned MIN_LAST_N = MIN_IN - LANES * (MIN_BEATS - 1);
  localparam int unsigned IW         = $clog2(MIN_BEATS + 1);

  logic             v_valid, v_ready, v_last;
  logic [DW-1:0]    v_data;
  logic [3:0]       v_n;
  logic [IW-1:0]    v_idx;

  vtag_pad_src #(
    .MIN_BEATS (MIN_BEATS),
    .MIN_LAST_N(MIN_LAST_N),
    .IW        (IW)
  ) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_valid_i(s_valid_i),
    .s_ready_o(s_ready_o),
    .s_data_i (s_data_i),
    .s_last_i (s_last_i),
    .s_be_i   (s_be_i),
    .v_valid_o(v_valid),
    .v_ready_i(v_ready),
    .v_data_o (v_data),
    .v_last_o (v_last),
    .v_n_o    (v_n),
    .v_idx_o  (v_idx)
  );

  vtag_align #(
    .IW(IW)
  ) u_align (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vid_i    (vid_i),
    .v_valid_i(v_valid),
    .v_ready_o(v_ready),
    .v_data_i (v_data),
    .v_last_i (v_last),
    .v_n_i    (v_n),
    .v_idx_i  (v_idx),
    .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i),
    .m_data_o (m_data_o),
    .m_last_o (m_last_o),
    .m_be_o   (m_be_o)
  );
endmodule

// File: rtl/vtag_chk.sv
module vtag_chk
  import vtag_pkg::*;
#(
  parameter int unsigned MIN_FRAME_BYTES = 64,
  parameter int unsigned FCS_BYTES       = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [11:0]      vid_i,
  input logic             s_valid_i,
  input logic             s_ready_o,
  input logic             s_last_i,
  input logic             m_valid_o,
  input logic             m_ready_i,
  input logic [DW-1:0]    m_data_o,
  input logic             m_last_o,
  input logic [LANES-1:0] m_be_o
);
  localparam int unsigned OUT_MIN  = MIN_FRAME_BYTES - FCS_BYTES;
  localparam logic [3:0]  MIN_LAST = 4'((OUT_MIN + LANES - 1) / LANES - 1);

  logic [3:0] ocnt_q;
  logic       in_done_q;
  logic       out_hs, out_end, in_end;

  assign out_hs  = m_valid_o && m_ready_i;
  assign out_end = out_hs && m_last_o;
  assign in_end  = s_valid_i && s_ready_o && s_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocnt_q    <= '0;
      in_done_q <= 1'b0;
    end else begin
      if (out_end) ocnt_q <= '0;
      else if (out_hs && ocnt_q != 4'hf) ocnt_q <= ocnt_q + 1'b1;
      if (out_end) in_done_q <= 1'b0;
      else if (in_end) in_done_q <= 1'b1;
    end
  end

  // R2
  tag_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && ocnt_q == 4'd1) |->
      (m_data_o[39:32] == 8'h81 && m_data_o[47:40] == 8'h00 &&
       m_data_o[55:48] == {4'h0, vid_i[11:8]} && m_data_o[63:56] == vid_i[7:0]));

  // R4
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_last_o) |-> (ocnt_q >= MIN_LAST));

  // R6
  last_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_last_o) |-> ($countones(m_be_o) == 1));

  // R7
  no_intake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_done_q |-> !s_ready_o);

  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=>
      (m_valid_o && $stable(m_data_o) && $stable(m_last_o) && $stable(m_be_o)));

  // R8
  ready_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> m_ready_i);
endmodule

bind vlan_tag_inserter vtag_chk #(
  .MIN_FRAME_BYTES(MIN_FRAME_BYTES),
  .FCS_BYTES      (FCS_BYTES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vid_i    (vid_i),
  .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o),
  .s_last_i (s_last_i),
  .m_valid_o(m_valid_o),
  .m_ready_i(m_ready_i),
  .m_data_o (m_data_o),
  .m_last_o (m_last_o),
  .m_be_o   (m_be_o)
);

// File: tb/sim_vlan_tag_inserter.sv
`timescale 1ns/1ps
module sim_vlan_tag_inserter;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [11:0] vid;
  logic        s_valid, s_ready, s_last;
  logic [63:0] s_data;
  logic [7:0]  s_be;
  logic        m_valid, m_ready, m_last;
  logic [63:0] m_data;
  logic [7:0]  m_be;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] in_b [0:255];
  logic [7:0] exp_b[0:319];
  logic [7:0] got  [0:319];

  always #2.5 clk = ~clk;

  vlan_tag_inserter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vid_i(vid),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .s_last_i(s_last), .s_be_i(s_be),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .m_last_o(m_last), .m_be_o(m_be)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // first mismatch in [lo,hi), -1 if none
  function automatic int first_diff(input int lo, input int hi);
    for (int i = lo; i < hi; i++) if (got[i] !== exp_b[i]) return i;
    return -1;
  endfunction

  task automatic run_frame(input int len, input int ready_pct, input int gap_pct);
    int nb, b, gn, exp_len, beats, cyc, d, pad_lo;
    bit presenting, in_done, done, stall_bad, stab_bad, prev_stall, be_ok;
    logic [63:0] prev_d;
    nb = (len + 7) / 8;
    b = 0; gn = 0; beats = 0; cyc = 0;
    presenting = 0; in_done = 0; done = 0; stall_bad = 0; stab_bad = 0;
    prev_stall = 0; be_ok = 1; prev_d = '0;
    for (int i = 0; i < len; i++) in_b[i] = 8'($urandom_range(255));
    in_b[12] = 8'h08;
    in_b[13] = $urandom_range(1) ? 8'h06 : 8'h00;
    @(negedge clk);
    vid = 12'($urandom_range(4095));
    // expected frame
    exp_len = ((len > 56) ? len : 56) + 4;
    for (int i = 0; i < 12; i++) exp_b[i] = in_b[i];
    exp_b[12] = 8'h81; exp_b[13] = 8'h00;
    exp_b[14] = {4'h0, vid[11:8]}; exp_b[15] = vid[7:0];
    for (int i = 12; i < exp_len - 4; i++) exp_b[i+4] = (i < len) ? in_b[i] : 8'h00;

    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (!presenting) s_valid = 1'b0;
      if (!presenting && !in_done && $urandom_range(99) >= gap_pct) begin
        presenting = 1;
        s_valid = 1'b1;
        s_last = (b == nb - 1);
        s_be = s_last ? (8'h01 << ((len - 1) % 8)) : 8'h00;
        for (int k = 0; k < 8; k++)
          s_data[k*8 +: 8] = (b*8 + k < len) ? in_b[b*8 + k] : 8'($urandom_range(1, 255));
      end
      m_ready = ($urandom_range(99) < ready_pct);
      #1;
      if (prev_stall && (!m_valid || m_data !== prev_d)) stab_bad = 1;
      prev_stall = m_valid && !m_ready;
      prev_d = m_data;
      if (in_done && s_ready) stall_bad = 1;
      if (m_valid && m_ready) begin
        int n;
        beats++;
        n = 8;
        if (m_last) begin
          n = 0;
          for (int k = 0; k < 8; k++) if (m_be[k]) n = k + 1;
          be_ok = ($countones(m_be) == 1);
          done = 1;
        end
        for (int k = 0; k < n; k++) if (gn < 320) begin got[gn] = m_data[k*8 +: 8]; gn++; end
      end
      if (s_valid && s_ready) begin
        presenting = 0;
        if (s_last) in_done = 1;
        b++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b0;

    check(done, "R8", $sformatf("frame end len=%0d", len), done, 1);
    check(gn == exp_len, "R4", $sformatf("length len=%0d", len), gn, exp_len);
    if (gn > exp_len) gn = exp_len;
    d = first_diff(0, (gn < 12) ? gn : 12);
    check(d < 0, "R1", $sformatf("header byte %0d", d), (d < 0) ? 0 : got[d], (d < 0) ? 0 : exp_b[d]);
    d = first_diff(12, (gn < 16) ? gn : 16);
    check(d < 0, "R2", $sformatf("tag byte %0d", d), (d < 0) ? 0 : got[d], (d < 0) ? 0 : exp_b[d]);
    d = first_diff(16, (gn < len + 4) ? gn : len + 4);
    check(d < 0, "R3", $sformatf("shifted byte %0d len=%0d", d, len), (d < 0) ? 0 : got[d], (d < 0) ? 0 : exp_b[d]);
    pad_lo = len + 4;
    d = first_diff(pad_lo, gn);
    check(d < 0, "R5", $sformatf("pad byte %0d len=%0d", d, len), (d < 0) ? 0 : got[d], (d < 0) ? 0 : exp_b[d]);
    check(be_ok, "R6", "last byte-enable one-hot", m_be, 0);
    check(beats == (exp_len + 7) / 8, "R7", $sformatf("beat count len=%0d", len), beats, (exp_len + 7) / 8);
    check(!stall_bad, "R7", "s_ready high after input end", stall_bad, 0);
    check(!stab_bad, "R8", "output changed under stall", stab_bad, 0);
  endtask

  initial begin
    int dir_len[21] = '{14, 15, 16, 20, 47, 48, 49, 52, 55, 56, 57, 59, 60, 61, 63, 64, 65, 68, 100, 127, 128};
    void'($urandom(32'd2024));
    rst_ni = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_be = '0; s_data = '0;
    m_ready = 1'b0; vid = '0;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R9", "m_valid in reset", m_valid, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R9", "m_valid idle after reset", m_valid, 0);
    foreach (dir_len[i]) run_frame(dir_len[i], 100, 0);
    foreach (dir_len[i]) run_frame(dir_len[i], 40, 30);
    for (int f = 0; f < 40; f++)
      run_frame($urandom_range(14, 200), $urandom_range(30, 100), $urandom_range(0, 50));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule